// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central hazard tracker for a small floating-point pipeline with four execution units: integer (also loads and stores), FP add, FP multiply and FP divide. Instructions arrive one at a time and in program order. Each arrives as a target unit, a destination register and two source registers. The block keeps one status entry per unit and a table that records, for each register, which unit will produce it. From this state it grants three things: issue of the presented instruction, the operand read of each unit, and the write-back of each unit.

The block has no renaming and no forwarding. An instruction waits at issue while its unit is occupied or while its destination is still owned by an earlier producer. It waits at operand read until every source has been produced. A finished unit waits at write-back until no other unit still needs the old value of its destination. The execution units sit outside the block. Each one reports completion with a one-cycle pulse after it has been granted its operand read.

Top module: `sb_hazard_ctl`

## Requirements
- R1: After reset no read or write-back grant is raised. `issue_ok` is high exactly when `in_valid` is high, the selected unit is idle and no active unit owns the destination. An accepted instruction occupies its unit from the next cycle. Unit codes: 0 integer, 1 FP add, 2 FP multiply, 3 FP divide.
- R2: An instruction whose unit is occupied stalls. It is accepted in the cycle after that unit's write-back grant.
- R3: An instruction whose destination is owned by another active unit stalls. It is accepted in the cycle after the owner's write-back grant.
- R4: When both sources are free at issue, the unit's read grant rises in the cycle after acceptance. It is raised for exactly one cycle per instruction.
- R5: A source owned by a producer delays the read grant until the cycle after the producer's write-back. Every waiting consumer, in either operand slot, is granted in that same cycle.
- R6: A write-back grant rises in the cycle after the unit's completion pulse when nothing blocks it. It never coincides with that unit's read grant.
- R7: A finished unit does not write back while another unit holds its destination as a ready, unread source. The grant follows in the cycle after that reader's read grant.
- R8: An instruction accepted in the same cycle as the write-back of the producer of one of its sources treats that source as already produced. Its read grant follows in the next cycle.
- R9: With `in_valid` low, the presented fields have no effect: no unit becomes occupied and no grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_unit | input | 2 | Target unit code |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| exec_done | input | 4 | Per-unit completion pulse |
| issue_ok | output | 1 | The presented instruction is accepted at this edge |
| rd_grant | output | 4 | Per-unit operand read grant |
| wb_grant | output | 4 | Per-unit result write-back grant |

## Verification
Write-back of a producer and issue of a consumer that reads the producer's register can fall in the same cycle. The bench computes the producer's write-back cycle from its latency and presents the consumer in exactly that cycle. It expects the consumer's read grant one cycle later, not a hang waiting for a producer that has already left. A related collision is a reader's operand read in the same cycle as a blocked writer that is waiting on it. The bench checks that the writer is granted only in the following cycle.

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_unit,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  input  logic [3:0]    exec_done,
  output logic          issue_ok,
  output logic [3:0]    rd_grant,
  output logic [3:0]    wb_grant
);
  localparam int NU = 4;

  logic [NU-1:0]   busy, rd_done, ex_done;
  logic [NU-1:0]   qj_v, qk_v, rj, rk;
  logic [RW-1:0]   fi [NU];
  logic [RW-1:0]   fj [NU];
  logic [RW-1:0]   fk [NU];
  logic [1:0]      qj [NU];
  logic [1:0]      qk [NU];
  logic [NREG-1:0] rs_v;
  logic [1:0]      rs_u [NREG];
  logic [NU-1:0]   war;
  logic            s1_wait, s2_wait;

  assign issue_ok = in_valid && !busy[in_unit] && !rs_v[in_dst];
  assign s1_wait  = rs_v[in_src1] && !wb_grant[rs_u[in_src1]];
  assign s2_wait  = rs_v[in_src2] && !wb_grant[rs_u[in_src2]];

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      war[u] = 1'b0;
      for (int v = 0; v < NU; v++)
        if (v != u && ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          war[u] = 1'b1;
      rd_grant[u] = busy[u] && !rd_done[u] && rj[u] && rk[u];
      wb_grant[u] = ex_done[u] && !war[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; rd_done <= '0; ex_done <= '0;
      qj_v <= '0; qk_v <= '0; rj <= '0; rk <= '0;
      rs_v <= '0;
      for (int u = 0; u < NU; u++) begin
        fi[u] <= '0; fj[u] <= '0; fk[u] <= '0; qj[u] <= '0; qk[u] <= '0;
      end
      for (int r = 0; r < NREG; r++) rs_u[r] <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (wb_grant[u]) begin
          busy[u] <= 1'b0; ex_done[u] <= 1'b0; rd_done[u] <= 1'b0;
          rs_v[fi[u]] <= 1'b0;
        end else if (exec_done[u]) ex_done[u] <= 1'b1;
        if (rd_grant[u]) begin
          rd_done[u] <= 1'b1; rj[u] <= 1'b0; rk[u] <= 1'b0;
        end
        if (qj_v[u] && wb_grant[qj[u]]) begin qj_v[u] <= 1'b0; rj[u] <= 1'b1; end
        if (qk_v[u] && wb_grant[qk[u]]) begin qk_v[u] <= 1'b0; rk[u] <= 1'b1; end
      end
      if (issue_ok) begin
        busy[in_unit] <= 1'b1; rd_done[in_unit] <= 1'b0; ex_done[in_unit] <= 1'b0;
        fi[in_unit] <= in_dst; fj[in_unit] <= in_src1; fk[in_unit] <= in_src2;
        qj[in_unit] <= rs_u[in_src1]; qj_v[in_unit] <= s1_wait; rj[in_unit] <= !s1_wait;
        qk[in_unit] <= rs_u[in_src2]; qk_v[in_unit] <= s2_wait; rk[in_unit] <= !s2_wait;
        rs_v[in_dst] <= 1'b1; rs_u[in_dst] <= in_unit;
      end
    end
  end

  for (genvar g = 0; g < NU; g++) begin : g_chk
    p_issue_claims_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_ok && in_unit == g) |=> (busy[g] && !rd_done[g]));
    p_free_after_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant[g] |=> !busy[g]);
    p_rd_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[g] |=> !rd_grant[g]);
    p_rd_wb_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_grant[g] && wb_grant[g]));
    p_done_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exec_done[g] |-> (busy[g] && rd_done[g] && !ex_done[g]));
  end
endmodule

// File: tb/test_sb_hazard_ctl.sv
`timescale 1ns/1ps
module test_sb_hazard_ctl;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] in_unit = 0;
  logic [4:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic [3:0] exec_done, rd_grant, wb_grant;
  logic issue_ok;
  int cyc = 0, ntot = 0, nbad = 0;
  int cnt [4];
  int rd_cyc [4];
  int wb_cyc [4];
  int rd_n [4];
  bit done_flag = 0;

  sb_hazard_ctl #(.NREG(32)) i_sb_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .exec_done(exec_done), .issue_ok(issue_ok), .rd_grant(rd_grant), .wb_grant(wb_grant));

  always #2 clk = ~clk;

  function automatic int lat_of(int u);
    case (u) 0: return 1; 1: return 2; 2: return 10; default: return 40; endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int u = 0; u < 4; u++)
      if (!rst_n) cnt[u] <= 0;
      else if (rd_grant[u]) cnt[u] <= lat_of(u);
      else if (cnt[u] > 0) cnt[u] <= cnt[u] - 1;
  end
  always_comb for (int u = 0; u < 4; u++) exec_done[u] = (cnt[u] == 1);

  always @(negedge clk)
    for (int u = 0; u < 4; u++) begin
      if (rd_grant[u]) begin rd_cyc[u] = cyc; rd_n[u] = rd_n[u] + 1; end
      if (wb_grant[u]) wb_cyc[u] = cyc;
    end

  task automatic chk(string req, int act, int exp);
    ntot++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(int u, int d, int a, int b);
    @(negedge clk);
    in_valid = 1; in_unit = 2'(u); in_dst = 5'(d); in_src1 = 5'(a); in_src2 = 5'(b);
    #1;
  endtask

  task automatic hold(output int c);
    while (!issue_ok) begin @(negedge clk); #1; end
    c = cyc;
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  initial begin
    int k, c, k2;
    for (int u = 0; u < 4; u++) begin rd_cyc[u] = -1; wb_cyc[u] = -1; rd_n[u] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset rd_grant", int'(rd_grant), 0);
    chk("R1 reset wb_grant", int'(wb_grant), 0);
    chk("R1 reset issue_ok idle", int'(issue_ok), 0);

    // R9: fields presented with in_valid low do nothing
    in_unit = 2; in_dst = 4; in_src1 = 1; in_src2 = 2; #1;
    chk("R9 issue_ok low without valid", int'(issue_ok), 0);
    repeat (4) @(negedge clk);
    chk("R9 no read grant", int'(rd_grant), 0);
    chk("R9 no read count", rd_n[2], 0);

    // R1 R4 R6: each unit alone
    for (int u = 0; u < 4; u++) begin
      int n0;
      n0 = rd_n[u];
      put(u, 20 + u, u + 1, u + 2);
      chk("R1 accepted at once", int'(issue_ok), 1);
      hold(k);
      drain();
      chk("R4 read after issue", rd_cyc[u], k + 1);
      chk("R4 one read", rd_n[u] - n0, 1);
      chk("R6 wb after done", wb_cyc[u], k + 1 + lat_of(u) + 1);
    end

    // R2 structural
    put(2, 2, 1, 1); hold(k);
    put(2, 3, 1, 1);
    chk("R2 busy unit stalls", int'(issue_ok), 0);
    hold(c);
    chk("R2 accept after wb", c, k + 13);
    drain();

    // R3 WAW
    put(1, 5, 1, 2); hold(k);
    put(2, 5, 3, 4);
    chk("R3 same dest stalls", int'(issue_ok), 0);
    hold(c);
    chk("R3 accept after owner wb", c, k + 5);
    drain();

    // R5 RAW sweep over producer/consumer pairs
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++)
        if (p != q) begin
          put(p, 8, 1, 2); hold(k);
          put(q, 9, 3, 8); hold(k2);
          drain();
          chk("R5 consumer waits producer", rd_cyc[q], k + lat_of(p) + 3);
        end

    // R5 several waiters woken together
    put(2, 14, 1, 2); hold(k);
    put(1, 15, 14, 14); hold(k2);
    put(3, 16, 14, 1); hold(k2);
    drain();
    chk("R5 waiter add", rd_cyc[1], k + 13);
    chk("R5 waiter div", rd_cyc[3], k + 13);

    // R7 WAR
    put(2, 6, 1, 2); hold(k);
    put(3, 11, 6, 12); hold(k2);
    put(1, 12, 1, 2); hold(k2);
    drain();
    chk("R7 reader read after producer", rd_cyc[3], k + 13);
    chk("R7 writer held for reader", wb_cyc[1], rd_cyc[3] + 1);
    drain();

    // R8 issue in the producer's write-back cycle
    put(2, 13, 1, 2); hold(k);
    while (cyc < k + 12) @(negedge clk);
    in_valid = 1; in_unit = 1; in_dst = 17; in_src1 = 13; in_src2 = 3; #1;
    chk("R8 producer wb this cycle", int'(wb_grant[2]), 1);
    chk("R8 consumer accepted", int'(issue_ok), 1);
    hold(k2);
    drain();
    chk("R8 consumer read next cycle", rd_cyc[1], k + 13);

    // R9 after activity: valid low still idle
    in_unit = 0; in_dst = 7; #1;
    repeat (3) @(negedge clk);
    chk("R9 idle rd_grant", int'(rd_grant), 0);
    chk("R9 idle wb_grant", int'(wb_grant), 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      ntot++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end
endmodule